// File: doc/BRIEF.md
# Branch Decision and Target Generator

This unit resolves control-transfer instructions for a small 8-bit processor core. Each cycle it takes the address of the instruction that follows the current one, a 4-bit instruction kind, the raw address and offset bytes of the instruction, and the operands that a condition may test: the accumulator, the 16-bit data pointer, the carry flag, one tested bit, two compare operands and a loop counter. It decides whether control leaves the sequential path, forms the resulting program counter, and reports the side effects that the fused instructions carry: a new carry after a compare, a decremented counter after a count-down loop, and a request to clear the tested bit.

Four target shapes are formed: a page-relative target that keeps the top five bits of the next-instruction address and inserts eleven bits from the instruction, a full 16-bit target, a signed 8-bit displacement from the next-instruction address, and the sum of accumulator and data pointer. All results are registered, so the outputs reflect the inputs presented one clock edge earlier. Fetch and operand memory accesses stay outside the block; the core supplies the operand values and performs the write-backs.

Top module: `br_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, every output becomes 0 after that edge.
- R2: Outputs are registered: the values appearing after a rising edge are computed from the inputs present at that edge; `pc_o` equals the destination when `taken_o` is 1 and `next_pc_i` otherwise.
- R3: Kind 1 (page jump) is always taken; its destination keeps `next_pc_i[15:11]`, takes bits 10:8 from `op_byte_i[7:5]` and bits 7:0 from `adr_lo_i`.
- R4: Kind 2 (long jump) is always taken with destination `{adr_hi_i, adr_lo_i}`.
- R5: Kind 3 (short jump) is always taken; its destination, shared by kinds 5 to 13, is `next_pc_i` plus `off_i` read as a two's-complement byte, modulo 65536.
- R6: Kind 4 (indirect jump) is always taken with destination `acc_i + dptr_i` modulo 65536, the accumulator zero-extended.
- R7: Kind 5 is taken when `acc_i` is zero and kind 6 when it is non-zero.
- R8: Kinds 7 and 8 are taken when `cy_i` is 1 and 0 respectively; kinds 9 and 10 are taken when `bit_i` is 1 and 0 respectively.
- R9: Kind 11 is taken when `bit_i` is 1, and `bit_clr_o` is 1 exactly in that case; every other kind leaves `bit_clr_o` at 0.
- R10: Kind 12 is taken when `cmp_a_i` differs from `cmp_b_i`; it sets `cy_we_o` to 1 and `cy_o` to 1 if `cmp_a_i < cmp_b_i` (unsigned) and 0 otherwise, taken or not. For every other kind `cy_we_o` is 0 and `cy_o` repeats `cy_i`.
- R11: `cnt_o` is `cnt_i - 1` modulo 256; kind 13 sets `cnt_we_o` to 1 and is taken when that result is non-zero. Other kinds leave `cnt_we_o` at 0.
- R12: Kinds 0, 14 and 15 are never taken, produce `pc_o = next_pc_i` and assert none of the write requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 4 | Instruction kind code |
| next_pc_i | input | 16 | Address of the following instruction |
| op_byte_i | input | 8 | First instruction byte (page-jump high bits in 7:5) |
| adr_hi_i | input | 8 | High byte of a long address |
| adr_lo_i | input | 8 | Low byte of a long or page address |
| off_i | input | 8 | Signed relative displacement |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | 16 | Data pointer value |
| cy_i | input | 1 | Current carry flag |
| bit_i | input | 1 | Value of the tested bit |
| cmp_a_i | input | 8 | First compare operand |
| cmp_b_i | input | 8 | Second compare operand |
| cnt_i | input | 8 | Loop counter before decrement |
| taken_o | output | 1 | Branch taken |
| pc_o | output | 16 | Resulting program counter |
| cy_o | output | 1 | Carry value to write |
| cy_we_o | output | 1 | Carry write request |
| cnt_o | output | 8 | Decremented counter |
| cnt_we_o | output | 1 | Counter write request |
| bit_clr_o | output | 1 | Request to clear the tested bit |

## Verification
The short jump is swept over all 256 displacements from next-instruction addresses at zero, near the top of memory and mid-range, which separates sign extension errors from missing wrap-around. Page jumps cover all eight high-bit values from addresses on both sides of a page boundary, showing whether the upper five bits are kept rather than added. The compare kind is run over the full 256 by 256 operand grid, which distinguishes signed from unsigned ordering and equal from unequal at every value, and the counter kind over all 256 start values, exposing the one-to-zero and zero-to-255 edges. Undefined kind codes and the flag and bit tests in all value combinations confirm that side effects appear only for their own kinds.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int HI_BITS = 3;
    localparam int PAGE_W  = HI_BITS + DATA_W;
    localparam int KIND_W  = 4;

    typedef enum logic [KIND_W-1:0] {
        K_NONE  = 4'd0,
        K_PAGE  = 4'd1,
        K_LONG  = 4'd2,
        K_SHORT = 4'd3,
        K_IND   = 4'd4,
        K_ACCZ  = 4'd5,
        K_ACCNZ = 4'd6,
        K_CYS   = 4'd7,
        K_CYC   = 4'd8,
        K_BITS  = 4'd9,
        K_BITC  = 4'd10,
        K_BITCLR= 4'd11,
        K_CMPNE = 4'd12,
        K_DECNZ = 4'd13
    } br_kind_e;

    typedef struct packed {
        logic              taken;
        logic              cy;
        logic              cy_we;
        logic [DATA_W-1:0] cnt;
        logic              cnt_we;
        logic              bit_clr;
    } br_cond_t;

    function automatic logic [ADDR_W-1:0] sext_off(input logic [DATA_W-1:0] off);
        return {{(ADDR_W-DATA_W){off[DATA_W-1]}}, off};
    endfunction

    function automatic logic [ADDR_W-1:0] page_join(input logic [ADDR_W-1:0] base,
                                                    input logic [HI_BITS-1:0] hi,
                                                    input logic [DATA_W-1:0] lo);
        return {base[ADDR_W-1:PAGE_W], hi, lo};
    endfunction

    function automatic logic uses_rel(input br_kind_e k);
        return (k == K_SHORT) || ((k >= K_ACCZ) && (k <= K_DECNZ));
    endfunction

endpackage

// File: rtl/br_target.sv
module br_target
    import br_pkg::*;
(
    input  br_kind_e          kind,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [DATA_W-1:0] op_byte,
    input  logic [DATA_W-1:0] adr_hi,
    input  logic [DATA_W-1:0] adr_lo,
    input  logic [DATA_W-1:0] off,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    output logic [ADDR_W-1:0] dest
);
    logic [ADDR_W-1:0] t_page, t_long, t_rel, t_ind;

    assign t_page = page_join(next_pc, op_byte[DATA_W-1 -: HI_BITS], adr_lo);
    assign t_long = {adr_hi, adr_lo};
    assign t_rel  = next_pc + sext_off(off);
    assign t_ind  = dptr + {{(ADDR_W-DATA_W){1'b0}}, acc};

    always_comb begin
        if (uses_rel(kind))      dest = t_rel;
        else if (kind == K_PAGE) dest = t_page;
        else if (kind == K_LONG) dest = t_long;
        else if (kind == K_IND)  dest = t_ind;
        else                     dest = next_pc;
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
(
    input  br_kind_e          kind,
    input  logic [DATA_W-1:0] acc,
    input  logic              cy,
    input  logic              tbit,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [DATA_W-1:0] cnt,
    output br_cond_t          res
);
    logic [DATA_W-1:0] dec;
    logic              acc_zero;

    assign dec      = cnt - 1'b1;
    assign acc_zero = (acc == '0);

    always_comb begin
        res         = '0;
        res.cy      = cy;
        res.cnt     = dec;
        unique case (kind)
            K_PAGE, K_LONG, K_SHORT, K_IND: res.taken = 1'b1;
            K_ACCZ:   res.taken = acc_zero;
            K_ACCNZ:  res.taken = !acc_zero;
            K_CYS:    res.taken = cy;
            K_CYC:    res.taken = !cy;
            K_BITS:   res.taken = tbit;
            K_BITC:   res.taken = !tbit;
            K_BITCLR: begin
                res.taken   = tbit;
                res.bit_clr = tbit;
            end
            K_CMPNE: begin
                res.taken = (cmp_a != cmp_b);
                res.cy_we = 1'b1;
                res.cy    = (cmp_a < cmp_b);
            end
            K_DECNZ: begin
                res.cnt_we = 1'b1;
                res.taken  = (dec != '0);
            end
            default: res.taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [DATA_W-1:0] op_byte_i,
    input  logic [DATA_W-1:0] adr_hi_i,
    input  logic [DATA_W-1:0] adr_lo_i,
    input  logic [DATA_W-1:0] off_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] dptr_i,
    input  logic              cy_i,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] cmp_a_i,
    input  logic [DATA_W-1:0] cmp_b_i,
    input  logic [DATA_W-1:0] cnt_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              cy_o,
    output logic              cy_we_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              cnt_we_o,
    output logic              bit_clr_o
);
    br_kind_e          kind;
    logic [ADDR_W-1:0] dest;
    br_cond_t          cres;
    br_cond_t          cres_q;
    logic [ADDR_W-1:0] pc_q;
    logic              live_q;

    assign kind = br_kind_e'(kind_i);

    br_target u_target (
        .kind    (kind),
        .next_pc (next_pc_i),
        .op_byte (op_byte_i),
        .adr_hi  (adr_hi_i),
        .adr_lo  (adr_lo_i),
        .off     (off_i),
        .acc     (acc_i),
        .dptr    (dptr_i),
        .dest    (dest)
    );

    br_cond u_cond (
        .kind  (kind),
        .acc   (acc_i),
        .cy    (cy_i),
        .tbit  (bit_i),
        .cmp_a (cmp_a_i),
        .cmp_b (cmp_b_i),
        .cnt   (cnt_i),
        .res   (cres)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cres_q <= '0;
            pc_q   <= '0;
            live_q <= 1'b0;
        end else begin
            cres_q <= cres;
            pc_q   <= cres.taken ? dest : next_pc_i;
            live_q <= 1'b1;
        end
    end

    assign taken_o   = cres_q.taken;
    assign pc_o      = pc_q;
    assign cy_o      = cres_q.cy;
    assign cy_we_o   = cres_q.cy_we;
    assign cnt_o     = cres_q.cnt;
    assign cnt_we_o  = cres_q.cnt_we;
    assign bit_clr_o = cres_q.bit_clr;

    // R12 / R2: an untaken result falls through to the next instruction
    assert_fallthrough_R12: assert property (@(posedge clk) disable iff (rst)
        (live_q && !taken_o) |-> (pc_o == $past(next_pc_i)));

    // R3: a page jump never leaves the 2 KB page of the next instruction
    assert_page_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(kind_i) == K_PAGE) |-> (pc_o[ADDR_W-1:PAGE_W] == $past(next_pc_i[ADDR_W-1:PAGE_W])));

    // R9: a bit-clear request only accompanies a taken branch
    assert_clr_taken_R9: assert property (@(posedge clk) disable iff (rst)
        bit_clr_o |-> taken_o);

    // R10: carry update after compare follows unsigned ordering of the operands
    assert_cmp_carry_R10: assert property (@(posedge clk) disable iff (rst)
        (live_q && cy_we_o) |-> (cy_o == ($past(cmp_a_i) < $past(cmp_b_i))));

    // R11: a count-down result is taken exactly when the written counter is non-zero
    assert_dec_taken_R11: assert property (@(posedge clk) disable iff (rst)
        cnt_we_o |-> (taken_o == (cnt_o != '0)));

    // R9 R10 R11: at most one side-effect request per result
    assert_one_effect_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cy_we_o, cnt_we_o, bit_clr_o}));

    // R1: reset clears the registered result
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!taken_o && pc_o == '0 && !cy_we_o && !cnt_we_o && !bit_clr_o));
endmodule

// File: tb/sim_br_resolve.sv
module sim_br_resolve;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  kind_i = '0;
    logic [15:0] next_pc_i = '0;
    logic [7:0]  op_byte_i = '0, adr_hi_i = '0, adr_lo_i = '0, off_i = '0, acc_i = '0;
    logic [15:0] dptr_i = '0;
    logic        cy_i = 1'b0, bit_i = 1'b0;
    logic [7:0]  cmp_a_i = '0, cmp_b_i = '0, cnt_i = '0;
    logic        taken_o, cy_o, cy_we_o, cnt_we_o, bit_clr_o;
    logic [15:0] pc_o;
    logic [7:0]  cnt_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    br_resolve u0 (
        .clk(clk), .rst(rst), .kind_i(kind_i), .next_pc_i(next_pc_i),
        .op_byte_i(op_byte_i), .adr_hi_i(adr_hi_i), .adr_lo_i(adr_lo_i),
        .off_i(off_i), .acc_i(acc_i), .dptr_i(dptr_i), .cy_i(cy_i), .bit_i(bit_i),
        .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .cnt_i(cnt_i),
        .taken_o(taken_o), .pc_o(pc_o), .cy_o(cy_o), .cy_we_o(cy_we_o),
        .cnt_o(cnt_o), .cnt_we_o(cnt_we_o), .bit_clr_o(bit_clr_o)
    );

    // Expected result computed from the requirement text.
    task automatic step(input string req);
        bit          e_tk, e_cy, e_cywe, e_cntwe, e_clr;
        int          dst;
        int          offs;
        logic [15:0] e_pc;
        logic [7:0]  e_cnt;
        offs    = (off_i >= 128) ? int'(off_i) - 256 : int'(off_i);
        e_cy    = cy_i;
        e_cywe  = 0;
        e_cntwe = 0;
        e_clr   = 0;
        e_cnt   = 8'((int'(cnt_i) + 255) % 256);
        dst     = (int'(next_pc_i) + offs + 65536) % 65536;
        case (kind_i)
            4'd1: begin e_tk = 1; dst = (int'(next_pc_i) / 2048) * 2048 + (int'(op_byte_i) / 32) * 256 + int'(adr_lo_i); end
            4'd2: begin e_tk = 1; dst = int'(adr_hi_i) * 256 + int'(adr_lo_i); end
            4'd3: e_tk = 1;
            4'd4: begin e_tk = 1; dst = (int'(dptr_i) + int'(acc_i)) % 65536; end
            4'd5: e_tk = (acc_i == 0);
            4'd6: e_tk = (acc_i != 0);
            4'd7: e_tk = cy_i;
            4'd8: e_tk = !cy_i;
            4'd9: e_tk = bit_i;
            4'd10: e_tk = !bit_i;
            4'd11: begin e_tk = bit_i; e_clr = bit_i; end
            4'd12: begin e_tk = (cmp_a_i != cmp_b_i); e_cywe = 1; e_cy = (int'(cmp_a_i) < int'(cmp_b_i)); end
            4'd13: begin e_cntwe = 1; e_tk = (e_cnt != 0); end
            default: e_tk = 0;
        endcase
        e_pc = e_tk ? 16'(dst) : next_pc_i;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (taken_o !== e_tk || pc_o !== e_pc || cy_o !== e_cy || cy_we_o !== e_cywe ||
            cnt_we_o !== e_cntwe || bit_clr_o !== e_clr || (e_cntwe && cnt_o !== e_cnt)) begin
            fails++;
            $display("FAIL %s kind=%0d: got tk=%0b pc=%h cy=%0b cywe=%0b cnt=%h cntwe=%0b clr=%0b, exp tk=%0b pc=%h cy=%0b cywe=%0b cnt=%h cntwe=%0b clr=%0b",
                     req, kind_i, taken_o, pc_o, cy_o, cy_we_o, cnt_o, cnt_we_o, bit_clr_o,
                     e_tk, e_pc, e_cy, e_cywe, e_cnt, e_cntwe, e_clr);
        end
    endtask

    initial begin : watchdog
        #1900000;
        fails++;
        $display("FAIL watchdog: got running, exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] pcs [4];
        logic [15:0] dps [4];
        pcs[0] = 16'h0015; pcs[1] = 16'h0000; pcs[2] = 16'hFFF0; pcs[3] = 16'h87FF;
        dps[0] = 16'h0000; dps[1] = 16'hFF80; dps[2] = 16'hFFFF; dps[3] = 16'h1234;

        // R1: outputs cleared under reset
        kind_i = 4'd2; adr_hi_i = 8'hAB; next_pc_i = 16'h1111; cy_i = 1; cmp_a_i = 3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (taken_o !== 0 || pc_o !== 0 || cy_o !== 0 || cy_we_o !== 0 || cnt_we_o !== 0 || bit_clr_o !== 0) begin
            fails++;
            $display("FAIL R1: got tk=%0b pc=%h cy=%0b, exp 0 0000 0", taken_o, pc_o, cy_o);
        end
        rst = 0;
        cy_i = 0;

        // R5 R2: short jump, every displacement from several bases
        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 256; o++) begin
                kind_i = 4'd3; next_pc_i = pcs[p]; off_i = 8'(o);
                step("R5");
            end

        // R3: page jump over all high-bit values, both sides of page edges
        for (int p = 0; p < 4; p++)
            for (int h = 0; h < 8; h++)
                for (int l = 0; l < 3; l++) begin
                    kind_i = 4'd1; next_pc_i = pcs[p] + 16'h07EB; op_byte_i = 8'((h << 5) | 5'h11);
                    adr_lo_i = (l == 0) ? 8'h00 : (l == 1) ? 8'h5A : 8'hFF;
                    step("R3");
                end

        // R4: long jump
        for (int h = 0; h < 256; h += 17)
            for (int l = 0; l < 256; l += 51) begin
                kind_i = 4'd2; adr_hi_i = 8'(h); adr_lo_i = 8'(l); next_pc_i = 16'h4321;
                step("R4");
            end

        // R6: indirect jump with wrap
        for (int d = 0; d < 4; d++)
            for (int a = 0; a < 256; a++) begin
                kind_i = 4'd4; acc_i = 8'(a); dptr_i = dps[d];
                step("R6");
            end

        // R7: accumulator zero tests
        next_pc_i = 16'h0100; off_i = 8'h80;
        for (int k = 5; k <= 6; k++)
            for (int a = 0; a < 256; a++) begin
                kind_i = 4'(k); acc_i = 8'(a);
                step("R7");
            end

        // R8 R9: flag and bit tests in all combinations
        off_i = 8'h7F;
        for (int k = 7; k <= 11; k++)
            for (int v = 0; v < 4; v++) begin
                kind_i = 4'(k); cy_i = v[0]; bit_i = v[1];
                step(k == 11 ? "R9" : "R8");
            end
        cy_i = 0; bit_i = 0;

        // R10: full unsigned compare grid
        next_pc_i = 16'h2000; off_i = 8'h10;
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++) begin
                kind_i = 4'd12; cmp_a_i = 8'(a); cmp_b_i = 8'(b); cy_i = 1'(a + b);
                step("R10");
            end

        // R11: count-down over every start value
        off_i = 8'hFE;
        for (int c = 0; c < 256; c++) begin
            kind_i = 4'd13; cnt_i = 8'(c);
            step("R11");
        end

        // R12: unused kind codes with active-looking operands
        for (int k = 0; k < 3; k++)
            for (int v = 0; v < 8; v++) begin
                kind_i = (k == 0) ? 4'd0 : (k == 1) ? 4'd14 : 4'd15;
                next_pc_i = 16'(16'hA000 + v * 16'h0123); bit_i = 1; cmp_a_i = 1; cmp_b_i = 2; cnt_i = 5;
                step("R12");
            end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule